// File: doc/BRIEF.md
# Fetch Address Sequencer with Hidden Return Stack

This block holds the program counter of a small 16-bit processor and decides where the next instruction is fetched from. On each cycle with the step strobe high, it looks at the current instruction word and the five status flags (zero, carry, overflow, negative, positive). From these it picks one of five actions: advance by one, absolute jump, flag-conditional relative branch, subroutine call or subroutine return. With the strobe low, nothing changes.

Return addresses are kept in a private last-in first-out store with its own pointer. Instructions cannot read or write this store. A call made when the store is full, or a return made when it is empty, is not trapped. Instead, a one-cycle status pulse is raised and the program counter simply advances. Instruction memory, flag generation and register writeback sit outside this block.

Top module: `pc_seq_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the fetch address is 0 and both status pulses are low.
- R2: With the step strobe low, the fetch address, the stack contents and the status outputs stay as they are; status pulses read low.
- R3: A stepped instruction that is not a jump, branch, call or return advances the fetch address by one, and 0xFFF wraps to 0x000.
- R4: A stepped instruction with bits 15:12 = 1000 loads the fetch address with bits 11:0.
- R5: A stepped instruction with bits 15:12 = 1001 is a branch. Bits 11:9 pick the condition: 000 zero set, 001 zero clear, 010 carry set, 011 carry clear, 100 overflow set, 101 overflow clear, 110 negative set, 111 positive set. When the condition holds, the fetch address becomes itself plus bits 8:0 read as a two's complement value (-256..+255), modulo 4096.
- R6: A branch whose condition does not hold advances the fetch address by one.
- R7: A stepped instruction with bits 15:12 = 1110 is a call. It pushes the fetch address plus one and loads the fetch address with bits 11:0.
- R8: A stepped instruction with bits 15:12 = 1111 and bits 4:0 = 00000 is a return. It loads the fetch address from the most recent push and removes that entry. Up to eight nested calls return in reverse order.
- R9: A call made while eight entries are held pushes nothing and advances the fetch address by one. The overflow output is high for exactly the next cycle, and the eight held entries remain intact.
- R10: A return made while the stack is empty advances the fetch address by one, and the underflow output is high for exactly the next cycle.
- R11: An instruction with bits 15:12 = 1111 and bits 4:0 not 00000 is not a return. It advances the fetch address by one and leaves the stack untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Execute the current instruction's control-flow effect this cycle |
| instr_i | input | 16 | Current instruction word |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_o_i | input | 1 | Overflow flag |
| flag_n_i | input | 1 | Negative flag |
| flag_p_i | input | 1 | Positive flag |
| fetch_addr_o | output | 12 | Current program counter / fetch address |
| stack_ovf_o | output | 1 | One-cycle pulse after a call made on a full stack |
| stack_unf_o | output | 1 | One-cycle pulse after a return made on an empty stack |

## Verification
Random instruction words are biased toward each opcode class and paired with random flag vectors and a random strobe. These patterns separate the eight branch conditions from one another and show whether each condition follows the right flag and polarity. Directed sequences cover the edge cases: a branch by -256 from address 0, which tests the modulo wrap, and +255, which tests the top of the offset range. A chain of nine calls followed by nine returns shows LIFO order, the full-stack drop and the empty-stack pulse. Near-miss return encodings with nonzero low bits separate a true return from a plain advance.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

   typedef enum logic [2:0] {
      ACT_ADV,
      ACT_JUMP,
      ACT_BRANCH,
      ACT_CALL,
      ACT_RET
   } pc_act_e;

   typedef enum logic [2:0] {
      CC_ZS = 3'b000,
      CC_ZC = 3'b001,
      CC_CS = 3'b010,
      CC_CC = 3'b011,
      CC_OS = 3'b100,
      CC_OC = 3'b101,
      CC_NS = 3'b110,
      CC_PS = 3'b111
   } cond_e;

   localparam logic [3:0] OPC_JUMP   = 4'b1000;
   localparam logic [3:0] OPC_BRANCH = 4'b1001;
   localparam logic [3:0] OPC_CALL   = 4'b1110;
   localparam logic [3:0] OPC_EXT    = 4'b1111;
   localparam int         RET_SUB_W  = 5;

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
   import pcu_pkg::*;
#(
   parameter int INSTR_W = 16,
   parameter int ADDR_W  = 12,
   parameter int OFF_W   = 9
) (
   input  logic [INSTR_W-1:0] instr_i,
   output pc_act_e            act_o,
   output logic [ADDR_W-1:0]  target_o,
   output logic [OFF_W-1:0]   offset_o,
   output cond_e              cond_o
);
   localparam int OPC_LSB  = INSTR_W - 4;
   localparam int COND_LSB = OFF_W;

   generate
      if (ADDR_W > OPC_LSB) begin : g_bad_addr
         $error("pcu_decode: address field does not fit under the opcode");
      end
      if (OFF_W + 3 > OPC_LSB) begin : g_bad_off
         $error("pcu_decode: condition and offset fields do not fit");
      end
   endgenerate

   logic [3:0]           opc;
   logic [RET_SUB_W-1:0] sub;

   assign opc      = instr_i[INSTR_W-1:OPC_LSB];
   assign sub      = instr_i[RET_SUB_W-1:0];
   assign target_o = instr_i[ADDR_W-1:0];
   assign offset_o = instr_i[OFF_W-1:0];
   assign cond_o   = cond_e'(instr_i[COND_LSB+2:COND_LSB]);

   always_comb begin
      unique case (opc)
         OPC_JUMP:   act_o = ACT_JUMP;
         OPC_BRANCH: act_o = ACT_BRANCH;
         OPC_CALL:   act_o = ACT_CALL;
         OPC_EXT:    act_o = (sub == '0) ? ACT_RET : ACT_ADV;
         default:    act_o = ACT_ADV;
      endcase
   end

endmodule

// File: rtl/pcu_cond_eval.sv
module pcu_cond_eval
   import pcu_pkg::*;
(
   input  cond_e cond_i,
   input  logic  z_i,
   input  logic  c_i,
   input  logic  o_i,
   input  logic  n_i,
   input  logic  p_i,
   output logic  taken_o
);
   always_comb begin
      unique case (cond_i)
         CC_ZS:   taken_o =  z_i;
         CC_ZC:   taken_o = ~z_i;
         CC_CS:   taken_o =  c_i;
         CC_CC:   taken_o = ~c_i;
         CC_OS:   taken_o =  o_i;
         CC_OC:   taken_o = ~o_i;
         CC_NS:   taken_o =  n_i;
         default: taken_o =  p_i;
      endcase
   end
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
   parameter int ADDR_W = 12,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [ADDR_W-1:0] push_data_i,
   output logic [ADDR_W-1:0] top_data_o,
   output logic              full_o,
   output logic              empty_o
);
   localparam int SP_W  = $clog2(DEPTH + 1);
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pcu_ret_stack: DEPTH must be at least 2");
      end
   endgenerate

   logic [SP_W-1:0]   sp_q;
   logic [ADDR_W-1:0] slot_q [DEPTH];
   logic [IDX_W-1:0]  top_idx;

   assign full_o  = (sp_q == SP_W'(DEPTH));
   assign empty_o = (sp_q == '0);
   assign top_idx = empty_o ? '0 : IDX_W'(sp_q - SP_W'(1));
   assign top_data_o = slot_q[top_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else if (push_i && !full_o) begin
         sp_q <= sp_q + SP_W'(1);
      end else if (pop_i && !empty_o) begin
         sp_q <= sp_q - SP_W'(1);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[i] <= '0;
         end else if (push_i && !full_o && (sp_q == SP_W'(i))) begin
            slot_q[i] <= push_data_i;
         end
      end
   end

   // R9
   push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);

   // R10
   pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);

   // R8
   pop_moves_pointer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i) |=> (sp_q == $past(sp_q) - SP_W'(1)));

endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
   import pcu_pkg::*;
#(
   parameter int INSTR_W     = 16,
   parameter int ADDR_W      = 12,
   parameter int OFF_W       = 9,
   parameter int STACK_DEPTH = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step_i,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic               flag_z_i,
   input  logic               flag_c_i,
   input  logic               flag_o_i,
   input  logic               flag_n_i,
   input  logic               flag_p_i,
   output logic [ADDR_W-1:0]  fetch_addr_o,
   output logic               stack_ovf_o,
   output logic               stack_unf_o
);
   localparam int EXT_W = ADDR_W - OFF_W;

   generate
      if (EXT_W < 1) begin : g_bad_ext
         $error("pc_seq_unit: offset must be narrower than the address");
      end
   endgenerate

   pc_act_e           act;
   cond_e             cond;
   logic [ADDR_W-1:0] target;
   logic [OFF_W-1:0]  offset;
   logic              taken;
   logic [ADDR_W-1:0] pc_q, pc_nxt, pc_inc, pc_rel, top_data;
   logic              full, empty, push, pop;
   logic              ovf_q, unf_q;

   pcu_decode #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
      .instr_i (instr_i),
      .act_o   (act),
      .target_o(target),
      .offset_o(offset),
      .cond_o  (cond)
   );

   pcu_cond_eval u_cond (
      .cond_i (cond),
      .z_i    (flag_z_i),
      .c_i    (flag_c_i),
      .o_i    (flag_o_i),
      .n_i    (flag_n_i),
      .p_i    (flag_p_i),
      .taken_o(taken)
   );

   assign push = step_i && (act == ACT_CALL) && !full;
   assign pop  = step_i && (act == ACT_RET)  && !empty;

   pcu_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stk (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push),
      .pop_i      (pop),
      .push_data_i(pc_inc),
      .top_data_o (top_data),
      .full_o     (full),
      .empty_o    (empty)
   );

   assign pc_inc = pc_q + ADDR_W'(1);
   assign pc_rel = pc_q + {{EXT_W{offset[OFF_W-1]}}, offset};

   always_comb begin
      unique case (act)
         ACT_JUMP:   pc_nxt = target;
         ACT_BRANCH: pc_nxt = taken ? pc_rel : pc_inc;
         ACT_CALL:   pc_nxt = full  ? pc_inc : target;
         ACT_RET:    pc_nxt = empty ? pc_inc : top_data;
         default:    pc_nxt = pc_inc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         ovf_q <= step_i && (act == ACT_CALL) && full;
         unf_q <= step_i && (act == ACT_RET)  && empty;
         if (step_i) begin
            pc_q <= pc_nxt;
         end
      end
   end

   assign fetch_addr_o = pc_q;
   assign stack_ovf_o  = ovf_q;
   assign stack_unf_o  = unf_q;

   // R2
   hold_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> ($stable(fetch_addr_o) && !stack_ovf_o && !stack_unf_o));

   // R4
   jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && instr_i[INSTR_W-1 -: 4] == OPC_JUMP)
      |=> (fetch_addr_o == $past(instr_i[ADDR_W-1:0])));

   // R9
   ovf_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stack_ovf_o |-> (fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1)));

   // R10
   unf_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stack_unf_o |-> (fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1)));

   // R9
   status_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stack_ovf_o, stack_unf_o}));

endmodule

// File: tb/pc_seq_unit_tb_top.sv
`timescale 1ns/1ps
module pc_seq_unit_tb_top;
   localparam int AW    = 12;
   localparam int DEPTH = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          step;
   logic [15:0]   instr;
   logic          fz, fc, fo, fn, fp;
   logic [AW-1:0] fetch_addr;
   logic          ovf, unf;

   always #10 clk = ~clk;

   pc_seq_unit dut_i (
      .clk(clk), .rst_n(rst_n), .step_i(step), .instr_i(instr),
      .flag_z_i(fz), .flag_c_i(fc), .flag_o_i(fo), .flag_n_i(fn), .flag_p_i(fp),
      .fetch_addr_o(fetch_addr), .stack_ovf_o(ovf), .stack_unf_o(unf)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   logic [AW-1:0] m_pc;
   logic [AW-1:0] m_stk [DEPTH];
   int            m_sp;
   bit            m_ovf, m_unf;

   task automatic check(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic bit cond_ok(logic [2:0] cc, logic z, c, o, n, p);
      case (cc)
         3'd0: return z;
         3'd1: return !z;
         3'd2: return c;
         3'd3: return !c;
         3'd4: return o;
         3'd5: return !o;
         3'd6: return n;
         default: return p;
      endcase
   endfunction

   function automatic string tag_of(logic [15:0] w, logic s);
      if (!s) return "R2";
      case (w[15:12])
         4'b1000: return "R4";
         4'b1001: return cond_ok(w[11:9], fz, fc, fo, fn, fp) ? "R5" : "R6";
         4'b1110: return (m_sp == DEPTH) ? "R9" : "R7";
         4'b1111: if (w[4:0] != 0) return "R11";
                  else return (m_sp == 0) ? "R10" : "R8";
         default: return "R3";
      endcase
   endfunction

   task automatic model_step(logic [15:0] w, logic s);
      logic [AW-1:0] inc;
      inc   = m_pc + 1'b1;
      m_ovf = 0;
      m_unf = 0;
      if (!s) return;
      case (w[15:12])
         4'b1000: m_pc = w[11:0];
         4'b1001: m_pc = cond_ok(w[11:9], fz, fc, fo, fn, fp)
                         ? m_pc + {{3{w[8]}}, w[8:0]} : inc;
         4'b1110: if (m_sp == DEPTH) begin m_ovf = 1; m_pc = inc; end
                  else begin m_stk[m_sp] = inc; m_sp++; m_pc = w[11:0]; end
         4'b1111: if (w[4:0] != 0) m_pc = inc;
                  else if (m_sp == 0) begin m_unf = 1; m_pc = inc; end
                  else begin m_sp--; m_pc = m_stk[m_sp]; end
         default: m_pc = inc;
      endcase
   endtask

   task automatic run_cycle(logic [15:0] w, logic s, logic [4:0] flags);
      string t;
      instr = w; step = s;
      {fz, fc, fo, fn, fp} = flags;
      t = tag_of(w, s);
      model_step(w, s);
      @(posedge clk);
      @(negedge clk);
      check(t, "fetch_addr", int'(fetch_addr), int'(m_pc));
      check(t, "overflow",   int'(ovf), int'(m_ovf));
      check(t, "underflow",  int'(unf), int'(m_unf));
   endtask

   function automatic logic [15:0] rand_instr();
      int k;
      k = $urandom_range(0, 9);
      case (k)
         0, 1: return 16'h8000 | 16'($urandom_range(0, 4095));
         2, 3, 4: return 16'h9000 | 16'($urandom_range(0, 4095));
         5: return 16'hE000 | 16'($urandom_range(0, 4095));
         6: return 16'hF000 | 16'($urandom_range(0, 127) << 5);
         7: return 16'hF000 | 16'($urandom_range(1, 4095));
         default: return 16'($urandom_range(0, 32767));
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 0; step = 0; instr = '0;
      {fz, fc, fo, fn, fp} = '0;
      m_pc = '0; m_sp = 0; m_ovf = 0; m_unf = 0;
      for (int i = 0; i < DEPTH; i++) m_stk[i] = '0;
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      check("R1", "fetch_addr", int'(fetch_addr), 0);
      check("R1", "overflow", int'(ovf), 0);
      check("R1", "underflow", int'(unf), 0);
      rst_n = 1;
      @(negedge clk);
      check("R1", "fetch_addr after release", int'(fetch_addr), 0);

      // R2: a jump with strobe low changes nothing
      run_cycle(16'h8ABC, 1'b0, 5'h1F);
      // R4 then R3 wrap
      run_cycle(16'h8FFF, 1'b1, 5'h00);
      run_cycle(16'h0000, 1'b1, 5'h00);
      // R5: -256 from 0 wraps to 0xF00 (zero set)
      run_cycle(16'h9100, 1'b1, 5'b10000);
      // R6: zero clear, not taken
      run_cycle(16'h9100, 1'b1, 5'b00000);
      // R5: +255 positive-set
      run_cycle(16'h9EFF, 1'b1, 5'b00001);
      // R11: near-miss return encodings
      run_cycle(16'hF001, 1'b1, 5'h00);
      run_cycle(16'hF010, 1'b1, 5'h00);
      // R7 nested calls to full depth, then R9 overflow
      for (int i = 0; i < DEPTH; i++) run_cycle(16'hE000 | 16'(i * 16 + 3), 1'b1, 5'h00);
      run_cycle(16'hE555, 1'b1, 5'h00);
      run_cycle(16'hE666, 1'b1, 5'h00);
      // R2 while full
      run_cycle(16'hF000, 1'b0, 5'h00);
      // R8 LIFO unwind, then R10 underflow
      for (int i = 0; i < DEPTH; i++) run_cycle(16'hF000, 1'b1, 5'h00);
      run_cycle(16'hF000, 1'b1, 5'h00);
      run_cycle(16'hF3E0, 1'b1, 5'h00);

      // constrained random mix, all requirements R2..R11
      for (int i = 0; i < 4000; i++) begin
         run_cycle(rand_instr(), ($urandom_range(0, 7) != 0), 5'($urandom_range(0, 31)));
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule